// File: doc/BRIEF.md
# Block Storage Controller Register Port

This block is the software-facing side of a small DMA disk controller. It holds the transfer set-up: a 64-bit memory buffer address kept as two 32-bit halves, a block count and the index of the first block. It also holds an interrupt enable and two read-only constants, the device capacity in blocks and the block size in bytes. Software launches a transfer by writing an operation code. The block then sends a one-cycle start command, tagged with the direction, to a separate transfer sequencer. The sequencer reports its state back, and that state is what software sees in the status register.

When the sequencer ends in one of its four finishing states, the interrupt line rises if the enable is non-zero. Software acknowledges by reading status. That read returns the finishing code, and the block pulses a return-to-idle request to the sequencer, which drops the interrupt. Set-up writes that arrive while the sequencer is not idle are discarded without an error.

Accesses use a simple request/response handshake. At most one response is outstanding at a time, and each response is held until it is taken.

Top module: `blk_reg_port`

## Requirements
- R1: After reset, the buffer halves, the block count and the first-block index read as 0, the interrupt enable reads as 1, and no response, start pulse or clear pulse is active.
- R2: `reqReady` is high exactly when no response is pending. A request accepted on a clock edge produces `rspValid` directly after that edge. The response is held with stable data and error flag until the edge on which `rspReady` is high.
- R3: Word offsets: 0x00 buffer low, 0x04 block count, 0x08 first block, 0x0C operation, 0x10 status, 0x14 interrupt enable, 0x18 capacity, 0x1C block size, 0x20 buffer high. Stored registers read back the last accepted value. `bufAddr` is {high, low}, and writing one half leaves the other half unchanged.
- R4: The following accesses return `rspErr`=1 with read data 0 and change no state: an offset whose two low bits are non-zero, an offset above 0x20, a write to status, capacity or block size, and a read of the operation register.
- R5: Writing operation code 1 (read, device to memory) or 2 (write, memory to device) while idle makes `startPulse` high for exactly one cycle after the accepting edge. `startIsRead` is 1 for code 1 and 0 for code 2. Any other code gives no pulse and an OK response.
- R6: While `engState` is not 0, writes to the buffer halves, the count, the first-block index and the operation register are acknowledged without error and change nothing.
- R7: Writes to the interrupt enable take effect in every sequencer state.
- R8: A status read returns `engState` as sampled on the accepting edge: 0 idle, 1 busy, 2 read done, 3 write done, 4 read failed, 5 write failed.
- R9: `irq` is high exactly when the interrupt enable is non-zero and `engState` is 2, 3, 4 or 5.
- R10: A status read accepted while `engState` is 2 to 5 makes `clearToIdle` high for exactly the cycle after the accepting edge. A status read in state 0 or 1 gives no pulse.
- R11: Capacity and block-size reads return the values of the `DEV_BLOCKS` and `BLOCK_BYTES` parameters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Request can be accepted |
| reqWrite | input | 1 | 1 write, 0 read |
| reqAddr | input | ADDR_W | Byte offset |
| reqWdata | input | 32 | Write data |
| rspValid | output | 1 | Response present |
| rspReady | input | 1 | Response taken |
| rspErr | output | 1 | Access rejected |
| rspRdata | output | 32 | Read data |
| bufAddr | output | 64 | Memory buffer address |
| blkCount | output | 32 | Blocks to transfer |
| firstLba | output | 32 | First block index |
| startPulse | output | 1 | One-cycle launch to the sequencer |
| startIsRead | output | 1 | Direction of the launch |
| clearToIdle | output | 1 | One-cycle return-to-idle request |
| engState | input | 3 | Sequencer state code |
| irq | output | 1 | Interrupt request |

## Verification
The response, its data, its error flag, the start pulse and the clear pulse all come from one register stage. They therefore appear in the cycle directly after the accepting edge. The bench samples all of them on the falling edge that follows that edge. `irq` is combinational from the enable and `engState`, so the bench checks it before driving a request, while the sequencer state is settled. The sequencer model in the bench acts on the edge after a pulse, so the next access sees busy or idle. Random accesses are compared with a register model that the bench updates from the requirements.

// File: rtl/blkreg_pkg.sv
package blkreg_pkg;

  localparam int NUM_REGS = 9;

  typedef enum logic [3:0] {
    RI_BUF_LO = 4'd0,
    RI_COUNT  = 4'd1,
    RI_LBA    = 4'd2,
    RI_OP     = 4'd3,
    RI_STATUS = 4'd4,
    RI_IRQEN  = 4'd5,
    RI_SIZE   = 4'd6,
    RI_BSIZE  = 4'd7,
    RI_BUF_HI = 4'd8
  } regIdx_e;

  localparam logic [2:0] ST_IDLE = 3'd0;
  localparam logic [2:0] ST_BUSY = 3'd1;

  localparam logic [31:0] OPC_READ  = 32'd1;
  localparam logic [31:0] OPC_WRITE = 32'd2;

  // strobes from control to datapath
  typedef struct packed {
    logic    wrBufLo;
    logic    wrBufHi;
    logic    wrCount;
    logic    wrLba;
    logic    wrIrqEn;
    logic    capture;
    logic    rdZero;
    regIdx_e rdSel;
  } strobe_t;

  function automatic logic isTerminal(input logic [2:0] st);
    return (st >= 3'd2) && (st <= 3'd5);
  endfunction

endpackage

// File: rtl/blkreg_ctrl.sv
module blkreg_ctrl
  import blkreg_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [31:0]       reqWdata,
  input  logic              rspReady,
  input  logic [2:0]        engState,
  output logic              reqReady,
  output logic              rspValid,
  output logic              rspErr,
  output logic              startPulse,
  output logic              startIsRead,
  output logic              clearToIdle,
  output strobe_t           strb
);

  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] wordIdx;
  logic             aligned;
  logic             inMap;
  logic             legal;
  logic             accept;
  logic             engIdle;
  regIdx_e          sel;
  logic             opRd;
  logic             opWr;
  logic             launch;
  logic             ack;

  assign wordIdx = reqAddr[ADDR_W-1:2];
  assign aligned = (reqAddr[1:0] == 2'b00);
  assign inMap   = aligned && (wordIdx < IDX_W'(NUM_REGS));
  assign sel     = regIdx_e'(wordIdx[3:0]);
  assign engIdle = (engState == ST_IDLE);
  assign accept  = reqValid && !rspValid;
  assign reqReady = !rspValid;

  always_comb begin
    if (!inMap) begin
      legal = 1'b0;
    end else if (reqWrite) begin
      legal = (sel != RI_STATUS) && (sel != RI_SIZE) && (sel != RI_BSIZE);
    end else begin
      legal = (sel != RI_OP);
    end
  end

  assign opRd   = (reqWdata == OPC_READ);
  assign opWr   = (reqWdata == OPC_WRITE);
  assign launch = accept && reqWrite && legal && (sel == RI_OP) && engIdle && (opRd || opWr);
  assign ack    = accept && !reqWrite && legal && (sel == RI_STATUS) && isTerminal(engState);

  always_comb begin
    strb.wrBufLo = accept && reqWrite && legal && engIdle && (sel == RI_BUF_LO);
    strb.wrBufHi = accept && reqWrite && legal && engIdle && (sel == RI_BUF_HI);
    strb.wrCount = accept && reqWrite && legal && engIdle && (sel == RI_COUNT);
    strb.wrLba   = accept && reqWrite && legal && engIdle && (sel == RI_LBA);
    strb.wrIrqEn = accept && reqWrite && legal && (sel == RI_IRQEN);
    strb.capture = accept;
    strb.rdZero  = reqWrite || !legal;
    strb.rdSel   = sel;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid    <= 1'b0;
      rspErr      <= 1'b0;
      startPulse  <= 1'b0;
      startIsRead <= 1'b0;
      clearToIdle <= 1'b0;
    end else begin
      startPulse  <= launch;
      clearToIdle <= ack;
      if (launch) startIsRead <= opRd;
      if (accept) begin
        rspValid <= 1'b1;
        rspErr   <= !legal;
      end else if (rspReady) begin
        rspValid <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/blkreg_data.sv
module blkreg_data
  import blkreg_pkg::*;
#(
  parameter logic [31:0] DEV_BLOCKS  = 32'h0010_0000,
  parameter logic [31:0] BLOCK_BYTES = 32'd512
) (
  input  logic        clk,
  input  logic        rstN,
  input  strobe_t     strb,
  input  logic [31:0] reqWdata,
  input  logic [2:0]  engState,
  output logic [31:0] rspRdata,
  output logic [63:0] bufAddr,
  output logic [31:0] blkCount,
  output logic [31:0] firstLba,
  output logic        irq
);

  logic [31:0] bufLo;
  logic [31:0] bufHi;
  logic [31:0] irqEn;
  logic [31:0] rdMux;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bufLo    <= '0;
      bufHi    <= '0;
      blkCount <= '0;
      firstLba <= '0;
      irqEn    <= 32'd1;
    end else begin
      if (strb.wrBufLo) bufLo    <= reqWdata;
      if (strb.wrBufHi) bufHi    <= reqWdata;
      if (strb.wrCount) blkCount <= reqWdata;
      if (strb.wrLba)   firstLba <= reqWdata;
      if (strb.wrIrqEn) irqEn    <= reqWdata;
    end
  end

  always_comb begin
    unique case (strb.rdSel)
      RI_BUF_LO: rdMux = bufLo;
      RI_COUNT:  rdMux = blkCount;
      RI_LBA:    rdMux = firstLba;
      RI_STATUS: rdMux = {29'd0, engState};
      RI_IRQEN:  rdMux = irqEn;
      RI_SIZE:   rdMux = DEV_BLOCKS;
      RI_BSIZE:  rdMux = BLOCK_BYTES;
      RI_BUF_HI: rdMux = bufHi;
      default:   rdMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspRdata <= '0;
    end else if (strb.capture) begin
      rspRdata <= strb.rdZero ? 32'd0 : rdMux;
    end
  end

  assign bufAddr = {bufHi, bufLo};
  assign irq     = (irqEn != 32'd0) && isTerminal(engState);

endmodule

// File: rtl/blk_reg_port.sv
module blk_reg_port
  import blkreg_pkg::*;
#(
  parameter int          ADDR_W      = 8,
  parameter logic [31:0] DEV_BLOCKS  = 32'h0010_0000,
  parameter logic [31:0] BLOCK_BYTES = 32'd512
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [31:0]       reqWdata,
  output logic              rspValid,
  input  logic              rspReady,
  output logic              rspErr,
  output logic [31:0]       rspRdata,
  output logic [63:0]       bufAddr,
  output logic [31:0]       blkCount,
  output logic [31:0]       firstLba,
  output logic              startPulse,
  output logic              startIsRead,
  output logic              clearToIdle,
  input  logic [2:0]        engState,
  output logic              irq
);

  strobe_t strb;

  blkreg_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .rspReady(rspReady),
    .engState(engState), .reqReady(reqReady), .rspValid(rspValid),
    .rspErr(rspErr), .startPulse(startPulse), .startIsRead(startIsRead),
    .clearToIdle(clearToIdle), .strb(strb)
  );

  blkreg_data #(.DEV_BLOCKS(DEV_BLOCKS), .BLOCK_BYTES(BLOCK_BYTES)) u_data (
    .clk(clk), .rstN(rstN), .strb(strb), .reqWdata(reqWdata),
    .engState(engState), .rspRdata(rspRdata), .bufAddr(bufAddr),
    .blkCount(blkCount), .firstLba(firstLba), .irq(irq)
  );

endmodule

// File: rtl/blkreg_chk.sv
module blkreg_chk (
  input logic        clk,
  input logic        rstN,
  input logic        reqValid,
  input logic        reqReady,
  input logic        rspValid,
  input logic        rspReady,
  input logic        rspErr,
  input logic [31:0] rspRdata,
  input logic        startPulse,
  input logic        clearToIdle,
  input logic        irq,
  input logic [2:0]  engState
);

  assert_rsp_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && !rspReady |=> rspValid && $stable(rspRdata) && $stable(rspErr));

  assert_rsp_cause_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rspValid) |-> $past(reqValid && reqReady));

  assert_start_single_R5: assert property (@(posedge clk) disable iff (!rstN)
    startPulse |=> !startPulse);

  assert_start_idle_R6: assert property (@(posedge clk) disable iff (!rstN)
    startPulse |-> $past(engState) == 3'd0);

  assert_irq_terminal_R9: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (engState >= 3'd2) && (engState <= 3'd5));

  assert_clear_terminal_R10: assert property (@(posedge clk) disable iff (!rstN)
    clearToIdle |-> rspValid && ($past(engState) >= 3'd2) && ($past(engState) <= 3'd5));

endmodule

bind blk_reg_port blkreg_chk u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .rspValid(rspValid), .rspReady(rspReady), .rspErr(rspErr),
  .rspRdata(rspRdata), .startPulse(startPulse), .clearToIdle(clearToIdle),
  .irq(irq), .engState(engState)
);

// File: tb/test_blk_reg_port.sv
module test_blk_reg_port;

  localparam logic [31:0] DEVB = 32'h0010_0000;
  localparam logic [31:0] BSZ  = 32'd512;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic        reqWrite = 1'b0;
  logic [7:0]  reqAddr = '0;
  logic [31:0] reqWdata = '0;
  logic        rspValid;
  logic        rspReady = 1'b0;
  logic        rspErr;
  logic [31:0] rspRdata;
  logic [63:0] bufAddr;
  logic [31:0] blkCount;
  logic [31:0] firstLba;
  logic        startPulse;
  logic        startIsRead;
  logic        clearToIdle;
  logic [2:0]  engState;
  logic        irq;

  int nTests = 0;
  int nFail  = 0;

  // bench model of the register contents
  logic [31:0] mLo = 0, mHi = 0, mCnt = 0, mLba = 0, mIrqEn = 1;

  // sequencer model
  logic [2:0] setVal = 0;
  logic       setTog = 1'b0;
  logic       lastTog = 1'b0;

  always #4 clk = ~clk;

  blk_reg_port #(.ADDR_W(8), .DEV_BLOCKS(DEVB), .BLOCK_BYTES(BSZ)) i_blk_reg_port (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rspValid(rspValid), .rspReady(rspReady), .rspErr(rspErr),
    .rspRdata(rspRdata), .bufAddr(bufAddr), .blkCount(blkCount),
    .firstLba(firstLba), .startPulse(startPulse), .startIsRead(startIsRead),
    .clearToIdle(clearToIdle), .engState(engState), .irq(irq)
  );

  always @(posedge clk) begin
    lastTog <= setTog;
    if (!rstN)                 engState <= 3'd0;
    else if (clearToIdle)      engState <= 3'd0;
    else if (startPulse)       engState <= 3'd1;
    else if (setTog != lastTog) engState <= setVal;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic setEng(input logic [2:0] v);
    setVal = v;
    setTog = ~setTog;
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic isTerm(input logic [2:0] s);
    return s >= 3'd2 && s <= 3'd5;
  endfunction

  // one access; checks response, pulses and irq against the model
  task automatic access(input bit wr, input logic [7:0] addr, input logic [31:0] wd,
                        input int holdCycles, input string req);
    logic [5:0]  idx;
    bit          okAcc;
    logic [31:0] expData;
    bit          expStart, expClear, idle;
    idx   = addr[7:2];
    idle  = (engState == 3'd0);
    okAcc = (addr[1:0] == 0) && (idx <= 6'd8) &&
            (wr ? !(idx == 6'd4 || idx == 6'd6 || idx == 6'd7) : (idx != 6'd3));
    expData = 0;
    if (okAcc && !wr) begin
      case (idx)
        6'd0: expData = mLo;
        6'd1: expData = mCnt;
        6'd2: expData = mLba;
        6'd4: expData = {29'd0, engState};
        6'd5: expData = mIrqEn;
        6'd6: expData = DEVB;
        6'd7: expData = BSZ;
        6'd8: expData = mHi;
        default: expData = 0;
      endcase
    end
    expStart = okAcc && wr && idx == 6'd3 && idle && (wd == 1 || wd == 2);
    expClear = okAcc && !wr && idx == 6'd4 && isTerm(engState);
    if (okAcc && wr) begin
      if (idle && idx == 6'd0) mLo = wd;
      if (idle && idx == 6'd8) mHi = wd;
      if (idle && idx == 6'd1) mCnt = wd;
      if (idle && idx == 6'd2) mLba = wd;
      if (idx == 6'd5) mIrqEn = wd;
    end
    chk(irq == ((mIrqEn != 0) && isTerm(engState)) || (okAcc && wr && idx == 6'd5),
        "R9", "irq", 64'(irq), 64'((mIrqEn != 0) && isTerm(engState)));
    chk(reqReady == 1'b1, "R2", "reqReady idle", 64'(reqReady), 1);
    reqValid = 1'b1; reqWrite = wr; reqAddr = addr; reqWdata = wd;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    chk(rspValid == 1'b1, "R2", "rspValid", 64'(rspValid), 1);
    chk(reqReady == 1'b0, "R2", "reqReady busy", 64'(reqReady), 0);
    chk(rspErr == !okAcc, req, "rspErr", 64'(rspErr), 64'(!okAcc));
    chk(rspRdata == expData, req, "rspRdata", 64'(rspRdata), 64'(expData));
    chk(startPulse == expStart, "R5", "startPulse", 64'(startPulse), 64'(expStart));
    if (expStart)
      chk(startIsRead == (wd == 1), "R5", "startIsRead", 64'(startIsRead), 64'(wd == 1));
    chk(clearToIdle == expClear, "R10", "clearToIdle", 64'(clearToIdle), 64'(expClear));
    for (int h = 0; h < holdCycles; h++) begin
      @(posedge clk);
      @(negedge clk);
      chk(rspValid && rspRdata == expData && rspErr == !okAcc, "R2", "held rsp",
          64'(rspRdata), 64'(expData));
    end
    rspReady = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rspReady = 1'b0;
    chk(rspValid == 1'b0, "R2", "rsp retired", 64'(rspValid), 0);
    chk(startPulse == 1'b0 && clearToIdle == 1'b0, "R5", "pulse width",
        64'({startPulse, clearToIdle}), 0);
    chk(bufAddr == {mHi, mLo} && blkCount == mCnt && firstLba == mLba, "R3",
        "outputs", bufAddr, {mHi, mLo});
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    chk(rspValid == 0 && startPulse == 0 && clearToIdle == 0, "R1", "reset outputs",
        64'({rspValid, startPulse, clearToIdle}), 0);
    access(0, 8'h00, 0, 0, "R1");
    access(0, 8'h04, 0, 0, "R1");
    access(0, 8'h08, 0, 0, "R1");
    access(0, 8'h14, 0, 0, "R1");
    access(0, 8'h20, 0, 0, "R1");
    // R11 constants
    access(0, 8'h18, 0, 0, "R11");
    access(0, 8'h1C, 0, 0, "R11");
    // R3 halves independent
    access(1, 8'h00, 32'h1111_2222, 0, "R3");
    access(1, 8'h20, 32'h0000_00AB, 0, "R3");
    access(1, 8'h00, 32'h3333_4444, 0, "R3");
    access(0, 8'h20, 0, 2, "R3");
    access(1, 8'h04, 32'd7, 0, "R3");
    access(1, 8'h08, 32'd99, 0, "R3");
    // R4 error cases
    access(1, 8'h10, 32'd3, 0, "R4");
    access(1, 8'h18, 32'd3, 0, "R4");
    access(0, 8'h0C, 0, 0, "R4");
    access(1, 8'h05, 32'd5, 0, "R4");
    access(0, 8'h24, 0, 0, "R4");
    access(1, 8'h40, 32'd1, 0, "R4");
    // R5 no-op and unknown code
    access(1, 8'h0C, 32'd0, 0, "R5");
    access(1, 8'h0C, 32'd9, 0, "R5");
    access(0, 8'h10, 0, 0, "R8");
    // R5 read launch, then R6 drop while busy
    access(1, 8'h0C, 32'd1, 0, "R5");
    access(0, 8'h10, 0, 0, "R8");
    access(1, 8'h00, 32'hDEAD_0000, 0, "R6");
    access(1, 8'h04, 32'd55, 0, "R6");
    access(1, 8'h0C, 32'd2, 0, "R6");
    access(0, 8'h10, 0, 0, "R10");
    // R9 / R10 terminal and acknowledge
    setEng(3'd2);
    access(1, 8'h20, 32'hFFFF, 0, "R6");
    access(0, 8'h10, 0, 1, "R10");
    access(0, 8'h10, 0, 0, "R10");
    // R7 enable writes in terminal state; disabled irq
    access(1, 8'h0C, 32'd2, 0, "R5");
    setEng(3'd5);
    access(1, 8'h14, 32'd0, 0, "R7");
    chk(irq == 0, "R9", "irq masked", 64'(irq), 0);
    access(1, 8'h14, 32'd4, 0, "R7");
    chk(irq == 1, "R9", "irq on", 64'(irq), 1);
    access(0, 8'h10, 0, 0, "R10");
    chk(irq == 0, "R9", "irq after ack", 64'(irq), 0);
    // random mix
    for (int i = 0; i < 400; i++) begin
      bit          wr;
      logic [7:0]  a;
      logic [31:0] d;
      wr = $urandom_range(0, 1) == 1;
      a  = 8'($urandom_range(0, 9) * 4);
      if ($urandom_range(0, 15) == 0) a = a | 8'($urandom_range(1, 3));
      if ($urandom_range(0, 31) == 0) a = 8'h40;
      d  = (a == 8'h0C) ? 32'($urandom_range(0, 3)) : $urandom;
      if (engState == 3'd1 && $urandom_range(0, 3) == 0)
        setEng(3'($urandom_range(1, 5)));
      access(wr, a, d, $urandom_range(0, 2), "R3");
    end
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    #1_000_000;
    nTests++;
    nFail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule